// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the arithmetic and logic unit of a 16-bit microcontroller core. Each cycle the core presents a destination operand `op_a_i`, a source operand `op_b_i`, an operation code, an operand size (byte or word) and a flag write mask. The unit returns the result and a write-back enable in the same cycle, combinationally. When `valid_i` is high, the status register is updated at the next rising clock edge. Fetching operands, addressing modes, decode and the stack belong to the core around it.

Two-operand operations are move, binary add with and without carry, subtract with and without carry, compare, packed-BCD decimal add, AND, bit test, bit clear, bit set and XOR. Single-operand operations work on `op_a_i`: rotate right through carry, arithmetic shift right, byte swap and sign extension of the low byte. Subtraction is formed as `op_a_i + ~op_b_i + 1`, so the carry flag means "no borrow". With subtract-with-carry, the current carry flag replaces the `+1`.

`op_i` encoding: 0 move, 1 add, 2 add with carry, 3 subtract with carry, 4 subtract, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 XOR, 11 AND, 12 rotate right through carry, 13 arithmetic shift right, 14 byte swap, 15 sign extend.

`flag_mask_i` bits: 0 = C, 1 = Z, 2 = N, 3 = V. Status register bits: C = bit 0, Z = bit 1, N = bit 2, V = bit 8. All other status bits are always 0.

Top module: `bw_alu`

## Requirements
- R1: While `rst_ni` is low, `status_o` is 0x0000. Reset is asynchronous.
- R2: Add (1) and add with carry (2) return `op_a_i + op_b_i (+C)` within the operand size. C is the carry out of the operand-width sum. V is set when two operands of the same sign give a result of the other sign.
- R3: Subtract (4), subtract with carry (3) and compare (5) compute `op_a_i + ~op_b_i + 1`; with subtract with carry, the current C replaces the 1. C is the carry out of the operand-width sum. V is the signed overflow of that sum.
- R4: N is bit 7 (byte) or bit 15 (word) of the result. Z is set when every result bit within the operand size is 0. N and Z are never both set by an operation that writes both.
- R5: AND (11) and bit test (7) return `op_a_i & op_b_i`. C is set when the result is nonzero, and V is cleared.
- R6: XOR (10) returns `op_a_i ^ op_b_i`. C is set when the result is nonzero. V is set when both operands have their sign bit set.
- R7: Decimal add (6) adds two packed-BCD operands and the current C. The result is the BCD sum modulo 100 (byte) or 10000 (word). C is set when the sum exceeds 99 or 9999. N and Z follow R4, and V is left unchanged.
- R8: Rotate right through carry (12) shifts the operand right by one. The old C enters the most significant bit of the operand size, and bit 0 goes to C. V is cleared.
- R9: Arithmetic shift right (13) shifts right by one and keeps the sign bit of the operand size. Bit 0 goes to C, and V is cleared.
- R10: Byte swap (14) and sign extend (15) always act on the full 16-bit word, whatever `byte_i` is. Byte swap exchanges the two bytes and leaves all flags unchanged. Sign extend copies bit 7 into bits 15:8, sets C when the result is nonzero, and clears V.
- R11: Move (0) returns `op_b_i`, bit clear (8) returns `op_a_i & ~op_b_i`, and bit set (9) returns `op_a_i | op_b_i`. None of the three changes any flag.
- R12: A flag changes only at a clock edge with `valid_i` high. It changes only if the operation defines it and its `flag_mask_i` bit is 1.
- R13: For byte-size operations other than 14 and 15, bits 15:8 of `result_o` are 0 when `dst_reg_i` is 1. When `dst_reg_i` is 0, they equal `op_a_i[15:8]`.
- R14: `wb_en_o` is high when `valid_i` is high and the operation is neither compare (5) nor bit test (7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte size, 0 = word size |
| dst_reg_i | input | 1 | Destination is a register |
| op_a_i | input | 16 | Destination (first) operand |
| op_b_i | input | 16 | Source (second) operand |
| flag_mask_i | input | 4 | Per-flag update enable: bit 0 C, bit 1 Z, bit 2 N, bit 3 V |
| result_o | output | 16 | Operation result |
| wb_en_o | output | 1 | Write result back to the destination |
| status_o | output | 16 | Status register: C bit 0, Z bit 1, N bit 2, V bit 8 |

## Verification
The only state is the four status flags. A wrong flag shows on `status_o` one clock edge after the operation that wrote it. The next carry-consuming operation (add with carry, subtract with carry, decimal add, rotate) then also turns it into a wrong `result_o` in the same cycle. A flag that is updated when it should be masked, or that is stale, shows up only on the first operation after it, so every vector first sets a known carry and then checks the full 16-bit status word.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_SUB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_DADD = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_AND  = 4'd11,
    OP_RRC  = 4'd12,
    OP_RRA  = 4'd13,
    OP_SWPB = 4'd14,
    OP_SXT  = 4'd15
  } alu_op_e;

  // Packed so that c is bit 0, matching the flag mask input.
  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam int unsigned SR_W  = 16;
  localparam int unsigned SR_C  = 0;
  localparam int unsigned SR_Z  = 1;
  localparam int unsigned SR_N  = 2;
  localparam int unsigned SR_V  = 8;
  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/bw_alu_adder.sv
module bw_alu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         invert_b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  import bw_alu_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;
  logic         sa, sb, sr;

  always_comb begin
    b_eff = invert_b_i ? ~b_i : b_i;
    wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    sum_o = wide[W-1:0];
    // byte carry = carry into bit 8, recovered from the sum bit
    carry_o = byte_i ? (wide[BYTE_W] ^ a_i[BYTE_W] ^ b_eff[BYTE_W]) : wide[W];
    sa = byte_i ? a_i[BYTE_W-1]   : a_i[W-1];
    sb = byte_i ? b_eff[BYTE_W-1] : b_eff[W-1];
    sr = byte_i ? wide[BYTE_W-1]  : wide[W-1];
    ovf_o = (sa == sb) && (sr != sa);
  end

endmodule

// File: rtl/bw_alu_bcd.sv
module bw_alu_bcd #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         byte_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  import bw_alu_pkg::*;

  localparam int unsigned NDIG      = W / 4;
  localparam int unsigned BYTE_DIGS = BYTE_W / 4;

  logic [NDIG:0] dc;

  assign dc[0] = cin_i;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    logic [3:0] a_d, b_d, s_d;
    logic [4:0] raw;
    logic       gt9;

    always_comb begin
      a_d = a_i[4*g +: 4];
      b_d = b_i[4*g +: 4];
      raw = {1'b0, a_d} + {1'b0, b_d} + {4'b0, dc[g]};
      gt9 = raw > 5'd9;
      s_d = gt9 ? (raw[3:0] + 4'd6) : raw[3:0];
      if (a_d <= 4'd9 && b_d <= 4'd9)
        AST_BCD_DIGIT: assert (s_d <= 4'd9); // R7
    end

    assign sum_o[4*g +: 4] = s_d;
    assign dc[g+1]         = gt9;
  end

  assign carry_o = byte_i ? dc[BYTE_DIGS] : dc[NDIG];

endmodule

// File: rtl/bw_alu_shift.sv
module bw_alu_shift #(
  parameter int unsigned W = 16
) (
  input  bw_alu_pkg::alu_op_e op_i,
  input  logic [W-1:0]        a_i,
  input  logic                cin_i,
  input  logic                byte_i,
  output logic [W-1:0]        res_o,
  output logic                cout_o
);
  import bw_alu_pkg::*;

  localparam int unsigned HI_W = W - BYTE_W;

  always_comb begin
    cout_o = a_i[0];
    unique case (op_i)
      OP_RRC:  res_o = byte_i ? {{HI_W{1'b0}}, cin_i, a_i[BYTE_W-1:1]}
                              : {cin_i, a_i[W-1:1]};
      OP_RRA:  res_o = byte_i ? {{HI_W{1'b0}}, a_i[BYTE_W-1], a_i[BYTE_W-1:1]}
                              : {a_i[W-1], a_i[W-1:1]};
      OP_SWPB: res_o = {a_i[BYTE_W-1:0], a_i[W-1:BYTE_W]};
      default: res_o = {{HI_W{a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
    endcase
  end

endmodule

// File: rtl/bw_alu_status.sv
module bw_alu_status (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  bw_alu_pkg::flags_t wr_mask_i,
  input  bw_alu_pkg::flags_t new_i,
  output bw_alu_pkg::flags_t cur_o,
  output logic [bw_alu_pkg::SR_W-1:0] sr_o
);
  import bw_alu_pkg::*;

  flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (upd_i) begin
      flags_q <= (flags_q & ~wr_mask_i) | (new_i & wr_mask_i);
    end
  end

  always_comb begin
    sr_o       = '0;
    sr_o[SR_C] = flags_q.c;
    sr_o[SR_Z] = flags_q.z;
    sr_o[SR_N] = flags_q.n;
    sr_o[SR_V] = flags_q.v;
  end

  assign cur_o = flags_q;

  AST_SR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(sr_o)); // R12
  AST_SR_MASK_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !wr_mask_i.v |=> $stable(sr_o[SR_V])); // R12

endmodule

// File: rtl/bw_alu.sv
module bw_alu #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [3:0]                  op_i,
  input  logic                        byte_i,
  input  logic                        dst_reg_i,
  input  logic [DATA_W-1:0]           op_a_i,
  input  logic [DATA_W-1:0]           op_b_i,
  input  logic [3:0]                  flag_mask_i,
  output logic [DATA_W-1:0]           result_o,
  output logic                        wb_en_o,
  output logic [bw_alu_pkg::SR_W-1:0] status_o
);
  import bw_alu_pkg::*;

  localparam int unsigned HI_W = DATA_W - BYTE_W;

  alu_op_e op;
  flags_t  cur_f, new_f, nat_f, wr_mask;
  logic    invert_b, add_cin, add_c, add_v, bcd_c, sh_c;
  logic    word_res, nz, sa, sb;
  logic [DATA_W-1:0] add_sum, bcd_sum, sh_res, raw;

  assign op = alu_op_e'(op_i);

  always_comb begin
    invert_b = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
    unique case (op)
      OP_ADDC, OP_SUBC: add_cin = cur_f.c;
      OP_SUB, OP_CMP:   add_cin = 1'b1;
      default:          add_cin = 1'b0;
    endcase
  end

  bw_alu_adder #(.W(DATA_W)) i_adder (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .invert_b_i (invert_b),
    .cin_i      (add_cin),
    .byte_i     (byte_i),
    .sum_o      (add_sum),
    .carry_o    (add_c),
    .ovf_o      (add_v)
  );

  bw_alu_bcd #(.W(DATA_W)) i_bcd (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .cin_i   (cur_f.c),
    .byte_i  (byte_i),
    .sum_o   (bcd_sum),
    .carry_o (bcd_c)
  );

  bw_alu_shift #(.W(DATA_W)) i_shift (
    .op_i   (op),
    .a_i    (op_a_i),
    .cin_i  (cur_f.c),
    .byte_i (byte_i),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  // result select
  always_comb begin
    unique case (op)
      OP_MOV:                                  raw = op_b_i;
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: raw = add_sum;
      OP_DADD:                                 raw = bcd_sum;
      OP_AND, OP_BIT:                          raw = op_a_i & op_b_i;
      OP_BIC:                                  raw = op_a_i & ~op_b_i;
      OP_BIS:                                  raw = op_a_i | op_b_i;
      OP_XOR:                                  raw = op_a_i ^ op_b_i;
      default:                                 raw = sh_res;
    endcase
  end

  // swap and sign extend are word operations regardless of size
  assign word_res = !byte_i || (op == OP_SWPB) || (op == OP_SXT);

  always_comb begin
    if (word_res) result_o = raw;
    else result_o = {dst_reg_i ? {HI_W{1'b0}} : op_a_i[DATA_W-1:BYTE_W], raw[BYTE_W-1:0]};
  end

  assign wb_en_o = valid_i && (op != OP_CMP) && (op != OP_BIT);

  // flag generation
  always_comb begin
    nz      = word_res ? (raw != '0) : (raw[BYTE_W-1:0] != '0);
    sa      = byte_i ? op_a_i[BYTE_W-1] : op_a_i[DATA_W-1];
    sb      = byte_i ? op_b_i[BYTE_W-1] : op_b_i[DATA_W-1];
    new_f.n = word_res ? raw[DATA_W-1] : raw[BYTE_W-1];
    new_f.z = !nz;
    new_f.c = 1'b0;
    new_f.v = 1'b0;
    nat_f   = '1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        new_f.c = add_c;
        new_f.v = add_v;
      end
      OP_DADD: begin
        new_f.c = bcd_c;
        nat_f.v = 1'b0;
      end
      OP_AND, OP_BIT, OP_SXT: new_f.c = nz;
      OP_XOR: begin
        new_f.c = nz;
        new_f.v = sa && sb;
      end
      OP_RRC, OP_RRA: new_f.c = sh_c;
      default: nat_f = '0;
    endcase
    wr_mask = nat_f & flags_t'(flag_mask_i);
  end

  bw_alu_status i_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (valid_i),
    .wr_mask_i (wr_mask),
    .new_i     (new_f),
    .cur_o     (cur_f),
    .sr_o      (status_o)
  );

  AST_ZN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && wr_mask.z && wr_mask.n |=> !(status_o[SR_Z] && status_o[SR_N])); // R4
  AST_NOFLAG_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op == OP_MOV || op == OP_BIC || op == OP_BIS || op == OP_SWPB)
    |=> $stable(status_o)); // R11
  AST_RRC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_RRC && flag_mask_i[0] |=> status_o[SR_C] == $past(op_a_i[0])); // R8
  AST_CMP_EQ_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_CMP && flag_mask_i[0] && op_a_i == op_b_i |=> status_o[SR_C]); // R3
  AST_BYTE_REG_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i && dst_reg_i && op != OP_SWPB && op != OP_SXT
    |-> result_o[DATA_W-1:BYTE_W] == '0); // R13

endmodule

// File: tb/test_bw_alu.sv
`timescale 1ns/100ps
module test_bw_alu;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic        byte_i = 1'b0;
  logic        dst_reg_i = 1'b0;
  logic [15:0] op_a_i = 16'h0;
  logic [15:0] op_b_i = 16'h0;
  logic [3:0]  flag_mask_i = 4'h0;
  logic [15:0] result_o;
  logic        wb_en_o;
  logic [15:0] status_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] res_s;
  logic        wb_s;

  always #2.5 clk_i = ~clk_i;

  bw_alu i_bw_alu (
    .clk_i, .rst_ni, .valid_i, .op_i, .byte_i, .dst_reg_i,
    .op_a_i, .op_b_i, .flag_mask_i, .result_o, .wb_en_o, .status_o
  );

  // {req, op, byte, dst_reg, carry_before, a, b, result, VNZC}
  localparam int NVEC = 34;
  localparam logic [62:0] VEC [NVEC] = '{
    {4'd2,  4'd1,  3'b000, 16'h7FFF, 16'h0001, 16'h8000, 4'b1100}, // R2
    {4'd2,  4'd1,  3'b000, 16'hFFFF, 16'h0001, 16'h0000, 4'b0011}, // R2
    {4'd2,  4'd2,  3'b001, 16'h1234, 16'h0001, 16'h1236, 4'b0000}, // R2
    {4'd4,  4'd1,  3'b110, 16'h12FF, 16'h0001, 16'h0000, 4'b0011}, // R4
    {4'd13, 4'd1,  3'b100, 16'hAB7F, 16'h0001, 16'hAB80, 4'b1100}, // R13
    {4'd3,  4'd4,  3'b000, 16'h0005, 16'h0003, 16'h0002, 4'b0001}, // R3
    {4'd3,  4'd4,  3'b000, 16'h0003, 16'h0005, 16'hFFFE, 4'b0100}, // R3
    {4'd3,  4'd3,  3'b000, 16'h0005, 16'h0003, 16'h0001, 4'b0001}, // R3
    {4'd3,  4'd5,  3'b000, 16'h8000, 16'h0001, 16'h7FFF, 4'b1001}, // R3
    {4'd3,  4'd5,  3'b110, 16'h0042, 16'h0042, 16'h0000, 4'b0011}, // R3
    {4'd7,  4'd6,  3'b000, 16'h1234, 16'h5678, 16'h6912, 4'b0000}, // R7
    {4'd7,  4'd6,  3'b001, 16'h9999, 16'h0000, 16'h0000, 4'b0011}, // R7
    {4'd7,  4'd6,  3'b110, 16'h0055, 16'h0055, 16'h0010, 4'b0001}, // R7
    {4'd7,  4'd6,  3'b000, 16'h4999, 16'h4001, 16'h9000, 4'b0100}, // R7
    {4'd5,  4'd11, 3'b000, 16'hF0F0, 16'h8F00, 16'h8000, 4'b0101}, // R5
    {4'd5,  4'd11, 3'b000, 16'h00FF, 16'hFF00, 16'h0000, 4'b0010}, // R5
    {4'd5,  4'd7,  3'b110, 16'h0080, 16'h00FF, 16'h0080, 4'b0101}, // R5
    {4'd6,  4'd10, 3'b000, 16'h8001, 16'h8000, 16'h0001, 4'b1001}, // R6
    {4'd6,  4'd10, 3'b110, 16'h0055, 16'h0055, 16'h0000, 4'b0010}, // R6
    {4'd11, 4'd8,  3'b001, 16'hFFFF, 16'h0F0F, 16'hF0F0, 4'b0001}, // R11
    {4'd11, 4'd9,  3'b000, 16'h1200, 16'h0034, 16'h1234, 4'b0010}, // R11
    {4'd11, 4'd0,  3'b000, 16'h0000, 16'hBEEF, 16'hBEEF, 4'b0010}, // R11
    {4'd11, 4'd0,  3'b111, 16'h1111, 16'hBEEF, 16'h00EF, 4'b0001}, // R11
    {4'd8,  4'd12, 3'b001, 16'h0002, 16'h0000, 16'h8001, 4'b0100}, // R8
    {4'd8,  4'd12, 3'b110, 16'h0081, 16'h0000, 16'h0040, 4'b0001}, // R8
    {4'd9,  4'd13, 3'b000, 16'h8003, 16'h0000, 16'hC001, 4'b0101}, // R9
    {4'd9,  4'd13, 3'b100, 16'h3482, 16'h0000, 16'h34C1, 4'b0100}, // R9
    {4'd10, 4'd14, 3'b001, 16'h12AB, 16'h0000, 16'hAB12, 4'b0001}, // R10
    {4'd10, 4'd14, 3'b110, 16'h12AB, 16'h0000, 16'hAB12, 4'b0010}, // R10
    {4'd10, 4'd15, 3'b000, 16'h0080, 16'h0000, 16'hFF80, 4'b0101}, // R10
    {4'd10, 4'd15, 3'b101, 16'h567F, 16'h0000, 16'h007F, 4'b0001}, // R10
    {4'd10, 4'd15, 3'b000, 16'hFF00, 16'h0000, 16'h0000, 4'b0010}, // R10
    {4'd2,  4'd1,  3'b000, 16'h8000, 16'h8000, 16'h0000, 4'b1011}, // R2
    {4'd3,  4'd3,  3'b111, 16'h0080, 16'h0001, 16'h007F, 4'b1001}  // R3
  };

  function automatic logic [15:0] sr_of(input logic [3:0] f);
    return {7'b0, f[3], 5'b0, f[2], f[1], f[0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic exec(input logic [3:0] op, input logic byt, input logic dst,
                      input logic [15:0] a, input logic [15:0] b,
                      input logic [3:0] mask, input logic vld);
    @(negedge clk_i);
    valid_i = vld; op_i = op; byte_i = byt; dst_reg_i = dst;
    op_a_i = a; op_b_i = b; flag_mask_i = mask;
    #1;
    res_s = result_o;
    wb_s  = wb_en_o;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "status in reset", status_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      automatic logic [62:0] v   = VEC[i];
      automatic string       req = $sformatf("R%0d", v[62:59]);
      automatic logic [3:0]  op  = v[58:55];
      automatic logic        cin = v[52];
      // establish carry via AND: 1&1 -> C=1, 0&0 -> C=0,Z=1
      exec(4'd11, 1'b0, 1'b1, {15'b0, cin}, {15'b0, cin}, 4'hF, 1'b1);
      exec(op, v[54], v[53], v[51:36], v[35:20], 4'hF, 1'b1);
      chk(req, $sformatf("vec %0d result", i), res_s, v[19:4]);
      chk("R14", $sformatf("vec %0d wb_en", i), {15'b0, wb_s},
          {15'b0, (op != 4'd5) && (op != 4'd7)});
      chk(req, $sformatf("vec %0d status", i), status_o, sr_of(v[3:0]));
    end

    // R12: flag mask selects updated flags
    exec(4'd1, 1'b0, 1'b1, 16'h8000, 16'h8000, 4'hF, 1'b1);
    chk("R12", "mask prep status", status_o, 16'h0103);
    exec(4'd1, 1'b0, 1'b1, 16'h0001, 16'h0001, 4'b0010, 1'b1);
    chk("R12", "mask Z only result", res_s, 16'h0002);
    chk("R12", "mask Z only status", status_o, 16'h0101);
    exec(4'd11, 1'b0, 1'b1, 16'h0000, 16'h0000, 4'b0000, 1'b1);
    chk("R12", "mask none status", status_o, 16'h0101);

    // R12 / R14: no valid, no flag change and no write-back
    exec(4'd1, 1'b0, 1'b1, 16'hFFFF, 16'h0001, 4'hF, 1'b0);
    chk("R14", "wb_en without valid", {15'b0, wb_s}, 16'h0000);
    chk("R12", "status held without valid", status_o, 16'h0101);

    // R1: asynchronous reset mid-run
    exec(4'd1, 1'b0, 1'b1, 16'h7FFF, 16'h0001, 4'hF, 1'b1);
    chk("R1", "pre-reset status", status_o, 16'h0104);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", "async reset status", status_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule